// File: doc/BRIEF.md
# Programmable Card Access Cycle Sequencer

This block times one memory or I/O access from a 16-bit host bus to a removable card. A cycle is started either by a host request pulse or by a DMA request and DMA acknowledge that are both active. Once started, the block runs three timed phases. In the setup phase it drives the card address, the card enables, the attribute-space select and any write data. In the command phase it asserts exactly one of four strobes: memory read, memory write, I/O read or I/O write. In the recovery phase the strobe is released while address, enables and write data are held. At the end it raises a one-clock done pulse.

Each phase length is programmed by its own 8-bit code. The code holds a 2-bit prescaler index and a 6-bit value, and the phase lasts prescaler × value + 1 clocks. Two sets of three codes are provided, and a select input picks the set when the cycle starts. While the command strobe is active, the card may hold a wait input high to stretch the command phase. The strobe then stays active for exactly two more clocks after wait drops, and never ends before the programmed command length has run out.

When a byte access to an odd address goes to a card with an 8-bit data path, the block swaps the two byte lanes and asserts only the low card enable. Read data is captured on the clock edge that ends the command strobe. All card-side outputs are active-high; pin polarity is handled outside the block.

Top module: `card_cycle_seq`

## Requirements
- R1: Each phase lasts P × N + 1 clocks, where the phase code is split into prescaler index = bits 7:6 and N = bits 5:0. P is PRE0..PRE3 for index 0..3, with defaults 1, 16, 68, 2048. In each 24-bit set the setup code sits in bits 7:0, the command code in 15:8 and the recovery code in 23:16. `tmg_sel` = 0 picks `tmg_set0` and 1 picks `tmg_set1`, sampled at cycle start.
- R2: The default codes, setup 8'h01, command 8'h06 and recovery 8'h03, give 2, 7 and 4 clocks.
- R3: A start moves the block from idle through setup, command and recovery and back to idle. During setup no strobe is active and address, enables and attribute select are driven. During command exactly one strobe is active, chosen by `req_io` and `req_write`. During recovery the strobe is off and the enables are held. `done` is high for exactly the first idle clock after recovery.
- R4: If `card_wait` is sampled high at a command-phase edge, the command phase lasts until the later of the programmed length and two clocks after the last clock in which wait was high.
- R5: `card_wait` has no effect outside the command phase.
- R6: A cycle starts when `dma_req` and `dma_ack` are both high while idle, and `busy` is high in the next clock. Either one alone starts nothing.
- R7: A start request while `busy` is high is dropped and is not queued.
- R8: For writes, `card_dout_en` is high and `card_dout` carries the (possibly steered) write data from the first setup clock to the last recovery clock. For reads `card_dout_en` stays low.
- R9: For reads, `rd_data` takes the card data present at the edge that ends the command strobe, and later card data changes leave it unchanged.
- R10: The access takes the 8-bit path if `card_8bit` is 1, or if it is an I/O cycle with `card_is16` = 0. `card_is16` is ignored otherwise. On the 8-bit path `card_ce` = 2'b01, and an odd (`req_addr[0]` = 1) byte access swaps the byte lanes in both directions. On the 16-bit path `card_ce` = 2'b11 for a word, 2'b01 for an even byte and 2'b10 for an odd byte, with lanes unswapped.
- R11: After reset the block is idle, and `busy`, `done`, all strobes, `card_ce`, `card_dout_en` and `rd_data` are 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Internal clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| host_req | input | 1 | Host start pulse |
| dma_req | input | 1 | DMA request |
| dma_ack | input | 1 | DMA acknowledge |
| req_write | input | 1 | 1 = write, 0 = read |
| req_io | input | 1 | 1 = I/O space, 0 = memory |
| req_attr | input | 1 | Attribute-space select |
| req_byte | input | 1 | 1 = byte access, 0 = word |
| req_addr | input | AW | Access address; bit 0 marks odd byte |
| req_wdata | input | 16 | Host write data |
| tmg_sel | input | 1 | Timing set select |
| tmg_set0 | input | 24 | Timing set 0 codes |
| tmg_set1 | input | 24 | Timing set 1 codes |
| card_8bit | input | 1 | Card uses 8-bit data path |
| card_is16 | input | 1 | Card reports 16-bit I/O |
| card_wait | input | 1 | Card wait request |
| card_din | input | 16 | Data from card |
| busy | output | 1 | Cycle in progress |
| done | output | 1 | One-clock end-of-cycle pulse |
| card_addr | output | AW | Address to card |
| card_ce | output | 2 | Card enables {high, low} |
| card_reg | output | 1 | Attribute-space select to card |
| card_oe | output | 1 | Memory read strobe |
| card_we | output | 1 | Memory write strobe |
| card_iord | output | 1 | I/O read strobe |
| card_iowr | output | 1 | I/O write strobe |
| card_dout | output | 16 | Data to card |
| card_dout_en | output | 1 | Drive enable for card_dout |
| rd_data | output | 16 | Captured read data |

## Verification
The bench builds the block with prescalers 1, 2, 3 and 5 instead of 1, 16, 68 and 2048. This keeps the longest phase at 316 clocks, so all 256 codes can be swept through all three phases and both sets within the run. The default codes use prescaler index 0 and keep their 2/7/4 clock lengths. With lengths this short, wait windows that start and stop on either side of the command count, byte-lane cases and DMA starts can be placed on exact clocks.

// File: rtl/ccs_pkg.sv
package ccs_pkg;

  typedef enum logic [1:0] {
    PH_IDLE  = 2'd0,
    PH_SETUP = 2'd1,
    PH_CMD   = 2'd2,
    PH_REC   = 2'd3
  } phase_e;

  localparam logic [7:0] DEF_SETUP_CODE = 8'h01;
  localparam logic [7:0] DEF_CMD_CODE   = 8'h06;
  localparam logic [7:0] DEF_REC_CODE   = 8'h03;

  // Clocks spent in a phase for one 8-bit code: prescaler * value + 1.
  function automatic int unsigned phase_clocks(input logic [7:0] code,
                                               input int unsigned p0,
                                               input int unsigned p1,
                                               input int unsigned p2,
                                               input int unsigned p3);
    int unsigned pre;
    case (code[7:6])
      2'd0:    pre = p0;
      2'd1:    pre = p1;
      2'd2:    pre = p2;
      default: pre = p3;
    endcase
    return pre * int'(code[5:0]) + 1;
  endfunction

  function automatic int unsigned max4(input int unsigned a, input int unsigned b,
                                       input int unsigned c, input int unsigned d);
    int unsigned m;
    m = a;
    if (b > m) m = b;
    if (c > m) m = c;
    if (d > m) m = d;
    return m;
  endfunction

endpackage

// File: rtl/ccs_timing.sv
module ccs_timing
  import ccs_pkg::*;
#(
  parameter int unsigned PRE0  = 1,
  parameter int unsigned PRE1  = 16,
  parameter int unsigned PRE2  = 68,
  parameter int unsigned PRE3  = 2048,
  parameter int unsigned CNT_W = 17
) (
  input  logic                     sel,
  input  logic [23:0]              set0,
  input  logic [23:0]              set1,
  output logic [2:0][CNT_W-1:0]    lens
);
  localparam int unsigned NPHASE = 3;

  logic [23:0] codes;
  assign codes = sel ? set1 : set0;

  // index 0 = setup, 1 = command, 2 = recovery
  for (genvar g = 0; g < NPHASE; g++) begin : g_len
    assign lens[g] = CNT_W'(phase_clocks(codes[g*8 +: 8], PRE0, PRE1, PRE2, PRE3));
  end
endmodule

// File: rtl/ccs_fsm.sv
module ccs_fsm
  import ccs_pkg::*;
#(
  parameter int unsigned CNT_W = 17
) (
  input  logic                  clk,
  input  logic                  rst_n,
  input  logic                  start,
  input  logic [2:0][CNT_W-1:0] lens,
  input  logic                  card_wait,
  output phase_e                phase,
  output logic                  cmd_end,
  output logic                  done
);
  logic [CNT_W-1:0] cnt;
  logic [CNT_W-1:0] cmd_len_q;
  logic [CNT_W-1:0] rec_len_q;
  logic [1:0]       tail;

  assign cmd_end = (phase == PH_CMD) && (cnt == '0) && !card_wait && (tail <= 2'd1);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      phase     <= PH_IDLE;
      cnt       <= '0;
      cmd_len_q <= '0;
      rec_len_q <= '0;
      tail      <= '0;
      done      <= 1'b0;
    end else begin
      done <= 1'b0;
      case (phase)
        PH_IDLE: begin
          if (start) begin
            phase     <= PH_SETUP;
            cnt       <= lens[0] - 1'b1;
            cmd_len_q <= lens[1];
            rec_len_q <= lens[2];
          end
        end
        PH_SETUP: begin
          if (cnt == '0) begin
            phase <= PH_CMD;
            cnt   <= cmd_len_q - 1'b1;
            tail  <= '0;
          end else begin
            cnt <= cnt - 1'b1;
          end
        end
        PH_CMD: begin
          if (card_wait)          tail <= 2'd2;
          else if (tail != 2'd0)  tail <= tail - 2'd1;
          if (cmd_end) begin
            phase <= PH_REC;
            cnt   <= rec_len_q - 1'b1;
          end else if (cnt != '0) begin
            cnt <= cnt - 1'b1;
          end
        end
        default: begin
          if (cnt == '0) begin
            phase <= PH_IDLE;
            done  <= 1'b1;
          end else begin
            cnt <= cnt - 1'b1;
          end
        end
      endcase
    end
  end

  // R3
  done_after_rec_chk: assert property (@(posedge clk) disable iff (!rst_n)
    done |-> $past(phase == PH_REC));

  // R3
  setup_order_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (phase == PH_SETUP) |=> (phase == PH_SETUP || phase == PH_CMD));

  // R4
  wait_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (phase == PH_CMD && card_wait) |=> (phase == PH_CMD));

  // R4
  wait_tail_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (phase == PH_CMD && $fell(card_wait)) |=> (phase == PH_CMD));
endmodule

// File: rtl/ccs_lanes.sv
module ccs_lanes
  import ccs_pkg::*;
#(
  parameter int unsigned AW = 26
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          start,
  input  phase_e        phase,
  input  logic          cmd_end,
  input  logic          req_write,
  input  logic          req_io,
  input  logic          req_attr,
  input  logic          req_byte,
  input  logic [AW-1:0] req_addr,
  input  logic [15:0]   req_wdata,
  input  logic          card_8bit,
  input  logic          card_is16,
  input  logic [15:0]   card_din,
  output logic [AW-1:0] card_addr,
  output logic [1:0]    card_ce,
  output logic          card_reg,
  output logic          card_oe,
  output logic          card_we,
  output logic          card_iord,
  output logic          card_iowr,
  output logic [15:0]   card_dout,
  output logic          card_dout_en,
  output logic [15:0]   rd_data
);
  logic [AW-1:0] addr_q;
  logic [15:0]   wdata_q;
  logic [1:0]    ce_q;
  logic          write_q, io_q, attr_q, swap_q, narrow_q;

  logic narrow_path, odd_byte, active, in_cmd;
  logic [1:0] ce_pick;

  assign narrow_path = card_8bit | (req_io & ~card_is16);
  assign odd_byte    = req_byte & req_addr[0];
  assign ce_pick     = narrow_path ? 2'b01 :
                       (req_byte ? (req_addr[0] ? 2'b10 : 2'b01) : 2'b11);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      addr_q   <= '0;
      wdata_q  <= '0;
      ce_q     <= '0;
      write_q  <= 1'b0;
      io_q     <= 1'b0;
      attr_q   <= 1'b0;
      swap_q   <= 1'b0;
      narrow_q <= 1'b0;
    end else if (start) begin
      addr_q   <= req_addr;
      wdata_q  <= req_wdata;
      ce_q     <= ce_pick;
      write_q  <= req_write;
      io_q     <= req_io;
      attr_q   <= req_attr;
      swap_q   <= narrow_path & odd_byte;
      narrow_q <= narrow_path;
    end
  end

  assign active = (phase != PH_IDLE);
  assign in_cmd = (phase == PH_CMD);

  assign card_addr    = active ? addr_q : '0;
  assign card_ce      = active ? ce_q : 2'b00;
  assign card_reg     = active & attr_q;
  assign card_oe      = in_cmd & ~io_q & ~write_q;
  assign card_we      = in_cmd & ~io_q &  write_q;
  assign card_iord    = in_cmd &  io_q & ~write_q;
  assign card_iowr    = in_cmd &  io_q &  write_q;
  assign card_dout_en = active & write_q;
  assign card_dout    = card_dout_en ? (swap_q ? {wdata_q[7:0], wdata_q[15:8]} : wdata_q) : 16'h0000;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)                    rd_data <= '0;
    else if (cmd_end && !write_q)  rd_data <= swap_q ? {card_din[7:0], card_din[15:8]} : card_din;
  end

  // R9
  rd_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !cmd_end |=> $stable(rd_data));

  // R8
  dout_with_ce_chk: assert property (@(posedge clk) disable iff (!rst_n)
    card_dout_en |-> (card_ce != 2'b00));

  // R10
  narrow_one_ce_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (active && narrow_q) |-> (card_ce == 2'b01));
endmodule

// File: rtl/card_cycle_seq.sv
module card_cycle_seq
  import ccs_pkg::*;
#(
  parameter int unsigned AW   = 26,
  parameter int unsigned PRE0 = 1,
  parameter int unsigned PRE1 = 16,
  parameter int unsigned PRE2 = 68,
  parameter int unsigned PRE3 = 2048
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          host_req,
  input  logic          dma_req,
  input  logic          dma_ack,
  input  logic          req_write,
  input  logic          req_io,
  input  logic          req_attr,
  input  logic          req_byte,
  input  logic [AW-1:0] req_addr,
  input  logic [15:0]   req_wdata,
  input  logic          tmg_sel,
  input  logic [23:0]   tmg_set0,
  input  logic [23:0]   tmg_set1,
  input  logic          card_8bit,
  input  logic          card_is16,
  input  logic          card_wait,
  input  logic [15:0]   card_din,
  output logic          busy,
  output logic          done,
  output logic [AW-1:0] card_addr,
  output logic [1:0]    card_ce,
  output logic          card_reg,
  output logic          card_oe,
  output logic          card_we,
  output logic          card_iord,
  output logic          card_iowr,
  output logic [15:0]   card_dout,
  output logic          card_dout_en,
  output logic [15:0]   rd_data
);
  localparam int unsigned MAX_PRE = max4(PRE0, PRE1, PRE2, PRE3);
  localparam int unsigned CNT_W   = $clog2(MAX_PRE * 63 + 2);

  logic [2:0][CNT_W-1:0] lens;
  phase_e phase;
  logic   cmd_end, start, dma_go;

  assign dma_go = dma_req & dma_ack;
  assign busy   = (phase != PH_IDLE);
  assign start  = !busy && (host_req || dma_go);

  ccs_timing #(.PRE0(PRE0), .PRE1(PRE1), .PRE2(PRE2), .PRE3(PRE3), .CNT_W(CNT_W)) u_timing (
    .sel  (tmg_sel),
    .set0 (tmg_set0),
    .set1 (tmg_set1),
    .lens (lens)
  );

  ccs_fsm #(.CNT_W(CNT_W)) u_fsm (
    .clk       (clk),
    .rst_n     (rst_n),
    .start     (start),
    .lens      (lens),
    .card_wait (card_wait),
    .phase     (phase),
    .cmd_end   (cmd_end),
    .done      (done)
  );

  ccs_lanes #(.AW(AW)) u_lanes (
    .clk          (clk),
    .rst_n        (rst_n),
    .start        (start),
    .phase        (phase),
    .cmd_end      (cmd_end),
    .req_write    (req_write),
    .req_io       (req_io),
    .req_attr     (req_attr),
    .req_byte     (req_byte),
    .req_addr     (req_addr),
    .req_wdata    (req_wdata),
    .card_8bit    (card_8bit),
    .card_is16    (card_is16),
    .card_din     (card_din),
    .card_addr    (card_addr),
    .card_ce      (card_ce),
    .card_reg     (card_reg),
    .card_oe      (card_oe),
    .card_we      (card_we),
    .card_iord    (card_iord),
    .card_iowr    (card_iowr),
    .card_dout    (card_dout),
    .card_dout_en (card_dout_en),
    .rd_data      (rd_data)
  );

  // R6
  dma_start_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (!busy && dma_req && dma_ack) |=> busy);

  // R3
  strobe_needs_ce_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (card_oe || card_we || card_iord || card_iowr) |-> (card_ce != 2'b00));

  // R3
  one_strobe_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $countones({card_oe, card_we, card_iord, card_iowr}) <= 1);
endmodule

// File: tb/card_cycle_seq_tb.sv
module card_cycle_seq_tb;
  localparam int unsigned AW = 26;
  localparam int unsigned PR [4] = '{1, 2, 3, 5};

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic host_req = 0, dma_req = 0, dma_ack = 0;
  logic req_write = 0, req_io = 0, req_attr = 0, req_byte = 0;
  logic [AW-1:0] req_addr = '0;
  logic [15:0] req_wdata = '0;
  logic tmg_sel = 0;
  logic [23:0] tmg_set0 = '0, tmg_set1 = '0;
  logic card_8bit = 0, card_is16 = 0, card_wait = 0;
  logic [15:0] card_din = '0;
  logic busy, done, card_reg, card_oe, card_we, card_iord, card_iowr, card_dout_en;
  logic [AW-1:0] card_addr;
  logic [1:0] card_ce;
  logic [15:0] card_dout, rd_data;

  int tests = 0, fails = 0;

  always #2 clk = ~clk;

  card_cycle_seq #(.AW(AW), .PRE0(1), .PRE1(2), .PRE2(3), .PRE3(5)) u_dut (
    .clk(clk), .rst_n(rst_n), .host_req(host_req), .dma_req(dma_req), .dma_ack(dma_ack),
    .req_write(req_write), .req_io(req_io), .req_attr(req_attr), .req_byte(req_byte),
    .req_addr(req_addr), .req_wdata(req_wdata), .tmg_sel(tmg_sel), .tmg_set0(tmg_set0),
    .tmg_set1(tmg_set1), .card_8bit(card_8bit), .card_is16(card_is16), .card_wait(card_wait),
    .card_din(card_din), .busy(busy), .done(done), .card_addr(card_addr), .card_ce(card_ce),
    .card_reg(card_reg), .card_oe(card_oe), .card_we(card_we), .card_iord(card_iord),
    .card_iowr(card_iowr), .card_dout(card_dout), .card_dout_en(card_dout_en), .rd_data(rd_data)
  );

  task automatic chk(input bit ok, input string tag, input longint act, input longint exp);
    tests++;
    if (!ok) begin
      fails++;
      $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
    end
  endtask

  function automatic int exp_len(input logic [7:0] code);
    return int'(PR[code[7:6]]) * int'(code[5:0]) + 1;
  endfunction

  function automatic logic [15:0] din_of(input int k);
    return 16'hA5C3 ^ 16'(k * 37);
  endfunction

  // One full access; wait is high in command clocks wa..wb (1-based).
  task automatic run_cycle(input bit sel, input logic [7:0] cs, input logic [7:0] cc,
                           input logic [7:0] cr, input bit wr, input bit io, input bit attr,
                           input bit byt, input bit odd, input bit c8, input bit is16,
                           input int wa, input int wb, input bit wsetup, input bit dma,
                           input bit hold);
    int s = 0, c = 0, r = 0, it = 0, ec, es, er;
    bit narrow, swap, bad_setup = 0, bad_cmd = 0, bad_rec = 0, bad_data = 0;
    logic [1:0] ece;
    logic [15:0] wd, ewd, erd, lastdin;
    logic [AW-1:0] ad;
    es = exp_len(cs); ec = exp_len(cc); er = exp_len(cr);
    if (wb >= wa) ec = (wb + 2 > ec) ? wb + 2 : ec;
    narrow = c8 | (io & ~is16);
    swap   = narrow & byt & odd;
    ece    = narrow ? 2'b01 : (byt ? (odd ? 2'b10 : 2'b01) : 2'b11);
    wd     = 16'h3C00 ^ {cs, cc};
    ewd    = swap ? {wd[7:0], wd[15:8]} : wd;
    ad     = AW'({cr, cc, cs}) & ~AW'(1) | AW'(odd);
    lastdin = 16'h0;
    @(negedge clk);
    tmg_sel  = sel;
    if (sel) begin tmg_set1 = {cr, cc, cs}; tmg_set0 = 24'hFFFFFF; end
    else     begin tmg_set0 = {cr, cc, cs}; tmg_set1 = 24'hFFFFFF; end
    req_write = wr; req_io = io; req_attr = attr; req_byte = byt;
    req_addr = ad; req_wdata = wd; card_8bit = c8; card_is16 = is16;
    if (dma) begin dma_req = 1; dma_ack = 1; end else host_req = 1;
    forever begin
      @(negedge clk);
      it++;
      if (!hold) host_req = 0;
      dma_req = 0; dma_ack = 0;
      req_wdata = ~wd; req_addr = ~ad; tmg_set0 = 24'h0; tmg_set1 = 24'h0;
      if (!busy || it > 4000) break;
      if (card_oe | card_we | card_iord | card_iowr) begin
        c++;
        if ({card_oe, card_we, card_iord, card_iowr} !=
            {!io && !wr, !io && wr, io && !wr, io && wr}) bad_cmd = 1;
        card_wait = (c >= wa && c <= wb);
        card_din  = din_of(c);
        lastdin   = din_of(c);
      end else if (c == 0) begin
        s++;
        card_wait = wsetup;
        if (card_ce != ece || card_addr != ad || card_reg != attr) bad_setup = 1;
      end else begin
        r++;
        card_wait = wsetup;
        card_din  = 16'hFFFF;
        if (card_ce != ece || card_addr != ad) bad_rec = 1;
      end
      if (card_dout_en != wr || (wr && card_dout != ewd)) bad_data = 1;
    end
    card_wait = 0; host_req = 0;
    erd = swap ? {lastdin[7:0], lastdin[15:8]} : lastdin;
    chk(it <= 4000, "R3 cycle finished", it, 0);
    chk(s == es, "R1 setup clocks", s, es);
    chk(c == ec, "R1/R4 command clocks", c, ec);
    chk(r == er, "R1 recovery clocks", r, er);
    chk(done == 1'b1, "R3 done on first idle clock", done, 1);
    chk(!bad_setup, "R3/R10 setup outputs", card_ce, ece);
    chk(!bad_cmd, "R3 single strobe", 1, 0);
    chk(!bad_rec, "R3 recovery holds enables", card_ce, ece);
    chk(!bad_data, "R8 write data drive", card_dout, ewd);
    if (!wr) chk(rd_data == erd, "R9/R10 read capture", rd_data, erd);
    @(negedge clk);
    chk(done == 1'b0 && busy == 1'b0, "R3 done one clock / R7 not queued", {done, busy}, 0);
  endtask

  initial begin
    repeat (3) @(negedge clk);
    // R11 reset state
    chk(!busy && !done && card_ce == 0 && !card_oe && !card_we && !card_iord && !card_iowr
        && !card_dout_en && rd_data == 0, "R11 reset state", {busy, done, card_ce}, 0);
    rst_n = 1;
    @(negedge clk);

    // R2 defaults with set 0
    run_cycle(0, 8'h01, 8'h06, 8'h03, 1, 0, 0, 0, 0, 0, 1, 1000, 0, 0, 0, 0);
    run_cycle(1, 8'h01, 8'h06, 8'h03, 0, 1, 1, 0, 0, 0, 1, 1000, 0, 0, 0, 0); // R2

    // R1 sweep of all codes through all phases, both sets
    for (int k = 0; k < 256; k++)
      run_cycle(k[0], 8'(k), 8'(k), 8'(k), k[1], k[2], k[3], 0, 0, 0, 1, 1000, 0, 0, 0, 0);
    run_cycle(0, 8'h45, 8'h82, 8'hC1, 0, 0, 0, 0, 0, 0, 1, 1000, 0, 0, 0, 0); // R1 mixed

    // R4 wait extension windows (C = 7)
    run_cycle(0, 8'h01, 8'h06, 8'h03, 0, 0, 0, 0, 0, 0, 1, 2, 6, 0, 0, 0);
    run_cycle(0, 8'h01, 8'h06, 8'h03, 0, 1, 0, 0, 0, 0, 1, 1, 9, 0, 0, 0);
    run_cycle(0, 8'h01, 8'h06, 8'h03, 1, 0, 0, 0, 0, 0, 1, 3, 3, 0, 0, 0);
    run_cycle(0, 8'h01, 8'h06, 8'h03, 0, 0, 0, 0, 0, 0, 1, 5, 12, 0, 0, 0);
    run_cycle(0, 8'h01, 8'h4A, 8'h03, 0, 0, 0, 0, 0, 0, 1, 2, 4, 0, 0, 0); // R4 short wait, long C

    // R5 wait during setup and recovery ignored
    run_cycle(0, 8'h05, 8'h06, 8'h05, 0, 0, 0, 0, 0, 0, 1, 1000, 0, 1, 0, 0);

    // R6 DMA start
    run_cycle(0, 8'h01, 8'h06, 8'h03, 1, 1, 0, 0, 0, 0, 1, 1000, 0, 0, 1, 0);
    @(negedge clk); dma_req = 1; dma_ack = 0;
    repeat (3) @(negedge clk);
    chk(!busy, "R6 request alone", busy, 0);
    dma_req = 0; dma_ack = 1;
    repeat (3) @(negedge clk);
    chk(!busy, "R6 acknowledge alone", busy, 0);
    dma_ack = 0;

    // R7 request held through the cycle is not queued
    run_cycle(0, 8'h02, 8'h03, 8'h02, 0, 0, 0, 0, 0, 0, 1, 1000, 0, 0, 0, 1);

    // R10 lane steering and enables
    for (int m = 0; m < 32; m++)
      run_cycle(0, 8'h01, 8'h02, 8'h01, m[0], m[1], 0, m[2], m[3], m[4], ~m[1],
                1000, 0, 0, 0, 0);
    for (int m = 0; m < 8; m++) // R10 card_is16 ignored on narrow card / memory
      run_cycle(0, 8'h01, 8'h02, 8'h01, m[0], 0, 0, 1, m[1], m[2], 1, 1000, 0, 0, 0, 0);

    $display("[TB] %0d tests run, %0d failed", tests, fails);
    $finish;
  end

  initial begin
    repeat (190000) @(posedge clk);
    fails++;
    tests++;
    $display("FAIL watchdog expired actual=1 expected=0");
    $display("[TB] %0d tests run, %0d failed", tests, fails);
    $finish;
  end
endmodule